// File: doc/BRIEF.md
# LIN Break Field Detector

This block watches the serial receive line of a node that answers as a LIN slave. It looks for the long dominant stretch that opens every frame. The line is not sampled on every clock. It is read once per bit time, whenever the baud generator presents its bit-tick strobe. A counter tracks how many bit times in a row have read dominant (0). When that run goes past the threshold of 11 bit times, a sticky break flag is raised. A break interrupt follows from that flag, gated by an enable.

A normal receiver reports framing errors partway through such a long low period. Software therefore turns normal reception off while it waits for a break. This detector has no receive-enable input and runs on its own. Its only gate is the LIN slave mode input. Software clears the flag by writing 0 to it, and writing 1 does nothing. The run counter saturates, so one long low period raises the flag only once. The line must go recessive before a new break can be recognised.

Top module: `lin_brk_detect`

## Requirements
- R1: The break flag (`brk_flag_o`) goes to 1 on the clock edge that takes the 12th consecutive dominant sample, that is, once the run exceeds THRESH_BITS = 11 bit times. A run of exactly 11 dominant samples leaves the flag at 0.
- R2: A recessive (1) sample taken on a bit tick resets the dominant run to zero. Counting then starts again from the next dominant sample.
- R3: The line is sampled only in clock cycles where `bit_tick_i` is 1. Values of `rxd_i` in other cycles have no effect.
- R4: Detection works only while `slave_mode_i` is 1. Ticks taken while it is 0 count nothing, and any cycle with `slave_mode_i` at 0 clears the run.
- R5: A cycle with `flag_wr_i` = 1 and `flag_wdata_i` = 0 clears the flag, and with it the interrupt, at that clock edge.
- R6: A write with `flag_wdata_i` = 1 has no effect on the flag: it neither sets nor clears it.
- R7: The run counter saturates. If the flag is cleared while the line stays dominant, it is not raised again. A new detection needs at least one recessive sample, followed by a fresh run longer than 11 bit times.
- R8: `brk_irq_o` equals `brk_flag_o` AND `brk_ie_i` in every cycle.
- R9: After a synchronous active-low reset, the flag and interrupt are 0 and the run count is zero.
- R10: If a detection and a clearing write occur in the same cycle, the detection wins and the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Serial receive line (0 = dominant) |
| bit_tick_i | input | 1 | One-cycle strobe, once per bit time |
| slave_mode_i | input | 1 | 1 = LIN slave operation, detection armed |
| flag_wr_i | input | 1 | CPU write strobe for the break flag |
| flag_wdata_i | input | 1 | Write data for the break flag (0 clears) |
| brk_ie_i | input | 1 | Break interrupt enable |
| brk_flag_o | output | 1 | Sticky break-detected flag |
| brk_irq_o | output | 1 | Break interrupt request |

## Verification
The bench builds the block with the default threshold of 11 bit times. This puts the exact 11-versus-12 boundary and the saturated counter value within a short run of ticks. Ticks are spaced by a random number of idle clocks, so the line can change between ticks in ways that must be ignored. Random traffic favours long dominant runs, mixed with writes and mode changes. A bench model predicts the flag and interrupt after every cycle. Directed cases cover simultaneous detection and clearing, and clearing during a run that continues.

// File: rtl/lin_brk_pkg.sv
// Package: shared defaults and types for the LIN break detector.
// Assumes: nothing beyond IEEE 1800-2017.
package lin_brk_pkg;
    // Number of dominant bit times that must be exceeded to flag a break.
    localparam int unsigned DEF_THRESH_BITS = 11;

    // CPU write to the break-flag location.
    typedef struct packed {
        logic en;
        logic data;
    } flag_wr_t;
endpackage

// File: rtl/lin_brk_run_counter.sv
// Module: counts consecutive dominant samples taken on bit ticks.
// It emits a single-cycle detect pulse when the run first exceeds THRESH_BITS.
// The counter saturates one above the threshold, so a continuing low period
// cannot pulse again until a recessive sample resets it.
// Assumes: bit_tick_i is a one-clock strobe and rxd_i is already synchronised.
module lin_brk_run_counter #(
    parameter int unsigned THRESH_BITS = lin_brk_pkg::DEF_THRESH_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic bit_tick_i,
    input  logic armed_i,
    output logic detect_o
);
    localparam int unsigned SAT   = THRESH_BITS + 1;
    localparam int unsigned CNT_W = $clog2(SAT + 1);
    localparam logic [CNT_W-1:0] SAT_V    = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH_BITS);

    logic [CNT_W-1:0] run_q;
    logic             sample_dom;

    // Purpose: mark a tick that samples a dominant level while armed.
    always_comb begin
        sample_dom = armed_i && bit_tick_i && !rxd_i;
        detect_o   = sample_dom && (run_q == THRESH_V);
    end

    // Purpose: update the dominant run length, saturating above the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed_i) begin
            run_q <= '0;
        end else if (bit_tick_i) begin
            if (rxd_i) begin
                run_q <= '0;
            end else if (run_q != SAT_V) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // The run never climbs past its saturation point.
    assert_run_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= SAT_V);

    // A recessive sample restarts the run.
    assert_recessive_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && bit_tick_i && rxd_i) |=> (run_q == '0));

    // Leaving slave mode empties the run.
    assert_unarmed_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_i |=> (run_q == '0));

    // Without a tick, the run length holds.
    assert_no_tick_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_i && !bit_tick_i) |=> $stable(run_q) || !$past(armed_i));
endmodule

// File: rtl/lin_brk_flag.sv
// Module: the sticky break flag and its interrupt.
// Set by the detect pulse, cleared by a CPU write of 0. A write of 1 is ignored,
// and a detection in the same cycle as a clear takes priority.
// Assumes: the detect pulse lasts one clock per break.
module lin_brk_flag (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  detect_i,
    input  lin_brk_pkg::flag_wr_t wr_i,
    input  logic                  ie_i,
    output logic                  flag_o,
    output logic                  irq_o
);
    logic flag_q;
    logic clr_req;

    // Purpose: decode a clearing write (only data 0 clears).
    always_comb clr_req = wr_i.en && !wr_i.data;

    // Purpose: hold the flag, with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (detect_i) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    // Purpose: gate the interrupt request with its enable.
    always_comb begin
        flag_o = flag_q;
        irq_o  = flag_q && ie_i;
    end

    // The flag only rises after a detect pulse.
    assert_rise_needs_detect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(detect_i));

    // The flag only falls after a clearing write.
    assert_fall_needs_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(wr_i.en && !wr_i.data));

    // Writing 1 with no detection leaves the flag unchanged.
    assert_write_one_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.en && wr_i.data && !detect_i) |=> $stable(flag_q));

    // Detection beats a simultaneous clear.
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        detect_i |=> flag_q);
endmodule

// File: rtl/lin_brk_detect.sv
// Module: top of the LIN synchronization break detector for a slave node.
// The line is sampled on each bit tick. A break is flagged once the dominant
// run exceeds THRESH_BITS. Detection does not depend on the receiver's enable;
// only slave_mode_i arms it.
// Assumes: rxd_i synchronised upstream; bit_tick_i from the baud generator.
module lin_brk_detect #(
    parameter int unsigned THRESH_BITS = lin_brk_pkg::DEF_THRESH_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic bit_tick_i,
    input  logic slave_mode_i,
    input  logic flag_wr_i,
    input  logic flag_wdata_i,
    input  logic brk_ie_i,
    output logic brk_flag_o,
    output logic brk_irq_o
);
    logic                  detect;
    lin_brk_pkg::flag_wr_t wr;

    // Purpose: bundle the CPU write into the shared type.
    always_comb begin
        wr.en   = flag_wr_i;
        wr.data = flag_wdata_i;
    end

    lin_brk_run_counter #(
        .THRESH_BITS(THRESH_BITS)
    ) u_run (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd_i     (rxd_i),
        .bit_tick_i(bit_tick_i),
        .armed_i   (slave_mode_i),
        .detect_o  (detect)
    );

    lin_brk_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .detect_i(detect),
        .wr_i    (wr),
        .ie_i    (brk_ie_i),
        .flag_o  (brk_flag_o),
        .irq_o   (brk_irq_o)
    );

    // The interrupt never stands without the flag and its enable.
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_irq_o |-> (brk_flag_o && brk_ie_i));

    // No break can be flagged outside slave mode.
    assert_mode_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode_i && !brk_flag_o) |=> !brk_flag_o);
endmodule

// File: tb/lin_brk_detect_tb.sv
module lin_brk_detect_tb;
    localparam int unsigned T = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1, tick = 1'b0, mode = 1'b1, wr = 1'b0, wd = 1'b1, ie = 1'b0;
    logic brk_flag, brk_irq;

    int unsigned n_chk = 0, n_fail = 0;
    int unsigned m_cnt = 0;
    logic        m_flag = 1'b0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    lin_brk_detect #(.THRESH_BITS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .bit_tick_i(tick),
        .slave_mode_i(mode), .flag_wr_i(wr), .flag_wdata_i(wd),
        .brk_ie_i(ie), .brk_flag_o(brk_flag), .brk_irq_o(brk_irq)
    );

    // Model: next run length from the requirements (R2, R3, R4, R7).
    function automatic int unsigned next_cnt(int unsigned c, logic md, logic tk, logic d);
        if (!md) return 0;
        if (!tk) return c;
        if (d) return 0;
        return (c == T + 1) ? c : c + 1;
    endfunction

    // Model: detection when the run passes the threshold (R1).
    function automatic logic det(int unsigned c, logic md, logic tk, logic d);
        return md && tk && !d && (c == T);
    endfunction

    task automatic check(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive one clock cycle, update the model, then check at the next negedge.
    task automatic cyc(logic d, logic tk, logic w, logic wdat, string req);
        logic dt;
        rxd = d; tick = tk; wr = w; wd = wdat;
        dt = det(m_cnt, mode, tk, d);
        m_cnt = next_cnt(m_cnt, mode, tk, d);
        if (dt) m_flag = 1'b1;
        else if (w && !wdat) m_flag = 1'b0;
        @(negedge clk);
        tick = 1'b0; wr = 1'b0;
        check(req, brk_flag, m_flag);
        check("R8", brk_irq, m_flag && ie);
    endtask

    task automatic ticks(logic d, int unsigned n, string req);
        for (int i = 0; i < n; i++) cyc(d, 1'b1, 1'b0, 1'b1, req);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E_3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R9 flag", brk_flag, 1'b0);
        check("R9 irq", brk_irq, 1'b0);
        ie = 1'b1;

        // R1: 11 dominant ticks do not flag; the 12th does.
        ticks(1'b0, T, "R1 eleven");
        check("R1 at eleven", brk_flag, 1'b0);
        ticks(1'b0, 1, "R1 twelve");
        check("R1 at twelve", brk_flag, 1'b1);
        // R7: clear while still low, no re-flag.
        cyc(1'b0, 1'b0, 1'b1, 1'b0, "R5 clear");
        ticks(1'b0, 20, "R7 saturated");
        check("R7 no reflag", brk_flag, 1'b0);
        ticks(1'b1, 1, "R7 recessive");
        ticks(1'b0, T + 1, "R7 new break");
        check("R7 reflag", brk_flag, 1'b1);
        // R6: writing 1 does nothing.
        cyc(1'b1, 1'b0, 1'b1, 1'b1, "R6 write one");
        check("R6 still set", brk_flag, 1'b1);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, "R5 clear");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, "R6 write one clear");
        check("R6 stays clear", brk_flag, 1'b0);

        // R2: a recessive sample in the middle restarts the run.
        ticks(1'b1, 1, "R2");
        ticks(1'b0, T, "R2");
        ticks(1'b1, 1, "R2 break");
        ticks(1'b0, T, "R2 after");
        check("R2 no flag", brk_flag, 1'b0);

        // R3: recessive between ticks is ignored.
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1, "R3 idle high");
        ticks(1'b0, 1, "R3");
        check("R3 flag after gap", brk_flag, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R5 clear");

        // R10: detect and clear in the same cycle.
        ticks(1'b0, T, "R10 setup");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, "R10");
        check("R10 set wins", brk_flag, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R5 clear");

        // R4: out of slave mode nothing counts, and mode drop clears run.
        mode = 1'b0;
        ticks(1'b0, 2 * T, "R4 off");
        check("R4 off", brk_flag, 1'b0);
        mode = 1'b1;
        ticks(1'b0, T - 2, "R4 part");
        mode = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b1, "R4 drop");
        mode = 1'b1;
        ticks(1'b0, T, "R4 restart");
        check("R4 run reset", brk_flag, 1'b0);
        ticks(1'b0, 1, "R4 on");
        check("R4 flag", brk_flag, 1'b1);

        // Random mix: long dominant runs, gaps, writes, enable and mode changes.
        for (int i = 0; i < 3000; i++) begin
            logic d, tk, w, wdt;
            ie   = ($urandom_range(0, 7) != 0);
            mode = ($urandom_range(0, 49) != 0);
            d    = ($urandom_range(0, 19) == 0);
            tk   = ($urandom_range(0, 2) == 0);
            w    = ($urandom_range(0, 29) == 0);
            wdt  = $urandom_range(0, 1);
            cyc(d, tk, w, wdt, "R1 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule